// File: doc/BRIEF.md
# I2C Passive Bus Monitor Receiver

This block is the receive side of an I2C target that can also watch the bus without disturbing it. It samples the clock and data wires in the system clock domain and recognises START and STOP conditions. It shifts in the address byte and the data bytes and compares each address against four programmable 7-bit target addresses. It raises an interrupt for the traffic it claims. Every received byte is placed in a holding register together with its kind (address or data), the transfer direction and the acknowledge level seen in the ninth clock.

In normal operation the block acknowledges a matching address and the data bytes of a write addressed to it. After each byte that raised the interrupt, it holds the clock low until software clears the interrupt. In monitor mode it never pulls the data wire low, so no data and no acknowledge. The clock wire is left alone as well unless a separate clock-hold enable is set. Monitor mode can also claim every address seen on the bus. The holding register stays unchanged for a whole nine-bit frame, which gives software that time to read a byte when it cannot stretch the clock.

Top module: `i2cmon_top`

## Requirements
- R1: While and right after reset, `scl_o` and `sda_o` are 1 (released), `irq` and `stop_evt` are 0 and `rx_data` is 0x00.
- R2: While `mon_en` is 1 (from the cycle after it is set), `sda_o` stays 1, so not even an acknowledge is driven.
- R3: While `mon_en` is 1 and `scl_en` is 0, `scl_o` stays 1 and no clock stretch happens.
- R4: When holding is allowed (`mon_en` is 0, or `scl_en` is 1), the first clock-low phase after the ninth bit of a byte that raised `irq` is stretched: `scl_o` is 0 until `irq_clr` is pulsed. `irq_clr` clears `irq` and releases `scl_o`. `scl_o` is never 0 while `irq` is 0.
- R5: An address byte raises `irq` when its upper seven bits equal an own address whose bit in `addr_en` is 1 (slot k occupies `own_addr[7k+6:7k]`). With `match_all` 0, or with `mon_en` 0, no other address raises `irq`. Data bytes of a claimed transfer also raise `irq`.
- R6: With `mon_en` and `match_all` both 1, every address byte raises `irq`, together with the data bytes that follow it.
- R7: Bytes are taken MSB first on SCL rising edges. `rx_data` is loaded on the eighth rising edge of a byte and then stays unchanged until the eighth rising edge of the next byte, at least nine rising edges later.
- R8: `rx_ack` holds the SDA level seen on the ninth rising edge of the last byte (0 = acknowledged).
- R9: With `mon_en` 0, the block drives SDA low in the acknowledge slot after a matching address byte, and after each data byte of a write (R/W = 0) to it. It does not acknowledge the data of a read, and it does not acknowledge a non-matching address.
- R10: A START in the middle of a byte abandons that byte without loading `rx_data`. The next eight bits are received as a fresh address byte.
- R11: A STOP gives a one-cycle `stop_evt` pulse and returns the receiver to idle. Clocked bits after it are ignored until the next START: no `irq`, no `rx_data` change, no acknowledge.
- R12: `rx_is_addr` is 1 when `rx_data` holds an address byte and 0 for a data byte. `rx_rw` is bit 0 of the last address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL wire level (asynchronous) |
| sda_i | input | 1 | SDA wire level (asynchronous) |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive: 0 pulls low, 1 releases |
| mon_en | input | 1 | Monitor mode enable |
| scl_en | input | 1 | Allow clock holding in monitor mode |
| match_all | input | 1 | In monitor mode, claim every address |
| own_addr | input | NUM_ADDR*7 | Own 7-bit addresses, slot k at bits 7k+6:7k |
| addr_en | input | NUM_ADDR | Per-slot enable for own addresses |
| irq_clr | input | 1 | Clears irq and releases a clock stretch |
| irq | output | 1 | Interrupt: a claimed byte was received |
| rx_data | output | 8 | Holding register with the last received byte |
| rx_is_addr | output | 1 | rx_data holds an address byte |
| rx_rw | output | 1 | R/W bit of the last address byte |
| rx_ack | output | 1 | SDA level in the ninth bit of the last byte |
| stop_evt | output | 1 | One-cycle pulse on STOP |

## Verification
A wrong bit counter or a missed START shows within one byte. `rx_data` then holds a shifted value, `rx_is_addr` has the wrong kind, or the acknowledge lands in the wrong slot. The bus master in the bench samples that acknowledge directly on the wire. A stretch flag that stays set, or that is set without a pending interrupt, freezes the clock wire at the next low phase. The next master bit then stalls and the bench counts it within a few cycles. A state that misses the return to idle shows as a spurious interrupt or a changed `rx_data` once bits are clocked after a STOP.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 7;
    localparam int FRAME_BITS = BYTE_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // Events seen on the synchronised bus wires
    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    // Holding register contents
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              is_addr;
        logic              rw;
        logic              ack;
    } rx_stat_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA
    } rx_state_t;

    // Clock holding is allowed in normal mode, or in monitor mode with the enable set
    function automatic logic may_hold(input logic mon, input logic hold_en);
        return !mon || hold_en;
    endfunction

    // A transfer is claimed by an own-address hit, or by match-all in monitor mode
    function automatic logic claims(input logic hit, input logic mon, input logic all);
        return hit || (mon && all);
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync
    import i2cmon_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                scl_ff[i] <= scl_ff[i-1];
                sda_ff[i] <= sda_ff[i-1];
            end
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            scl_d     <= scl_s;
            sda_d     <= sda_s;
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.sda   = sda_s;
        ev.rise  = scl_s && !scl_d;
        ev.fall  = !scl_s && scl_d;
        ev.start = scl_s && scl_d && sda_d && !sda_s;
        ev.stop  = scl_s && scl_d && !sda_d && sda_s;
    end

endmodule

// File: rtl/i2cmon_match.sv
module i2cmon_match
    import i2cmon_pkg::*;
#(
    parameter int NUM_ADDR = 4
) (
    input  logic [NUM_ADDR*ADDR_W-1:0] own_addr,
    input  logic [NUM_ADDR-1:0]        addr_en,
    input  logic [ADDR_W-1:0]          cand,
    output logic                       hit
);

    logic [NUM_ADDR-1:0] slot_hit;

    generate
        for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
            assign slot_hit[g] = addr_en[g] && (own_addr[g*ADDR_W +: ADDR_W] == cand);
        end
    endgenerate

    assign hit = |slot_hit;

endmodule

// File: rtl/i2cmon_rx.sv
module i2cmon_rx
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              mon_en,
    input  logic              scl_en,
    input  logic              match_all,
    input  logic              hit,
    input  logic              irq_clr,
    output logic [ADDR_W-1:0] cand,
    output rx_stat_t          stat,
    output logic              irq,
    output logic              stop_evt,
    output logic              sda_o,
    output logic              scl_o
);

    rx_state_t         state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-2:0] shreg;
    logic              claimed;
    logic              ack_want;
    logic              ack_drv;
    logic              post_ack;
    logic              stretch;
    logic              byte_done;
    logic              ack_rise;
    logic              hold_ok;
    logic              active;

    assign cand    = shreg;
    assign hold_ok = may_hold(mon_en, scl_en);

    always_comb begin
        active    = (state != RX_IDLE) && !ev.start && !ev.stop;
        byte_done = active && ev.rise && (bitcnt == CNT_W'(BYTE_W - 1));
        ack_rise  = active && ev.rise && (bitcnt == CNT_W'(BYTE_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            stat     <= '0;
            claimed  <= 1'b0;
            ack_want <= 1'b0;
            ack_drv  <= 1'b0;
            post_ack <= 1'b0;
            stretch  <= 1'b0;
            irq      <= 1'b0;
            stop_evt <= 1'b0;
            sda_o    <= 1'b1;
            scl_o    <= 1'b1;
        end else begin
            stop_evt <= 1'b0;
            if (irq_clr) begin
                irq     <= 1'b0;
                stretch <= 1'b0;
            end
            if (ev.start) begin
                state    <= RX_ADDR;
                bitcnt   <= '0;
                claimed  <= 1'b0;
                ack_want <= 1'b0;
                ack_drv  <= 1'b0;
                post_ack <= 1'b0;
            end else if (ev.stop) begin
                state    <= RX_IDLE;
                stop_evt <= 1'b1;
                claimed  <= 1'b0;
                ack_want <= 1'b0;
                ack_drv  <= 1'b0;
                post_ack <= 1'b0;
            end else if (state != RX_IDLE) begin
                if (ack_rise) begin
                    stat.ack <= ev.sda;
                    bitcnt   <= '0;
                    post_ack <= 1'b1;
                end else if (ev.rise) begin
                    shreg  <= {shreg[BYTE_W-3:0], ev.sda};
                    bitcnt <= bitcnt + 1'b1;
                end
                if (byte_done) begin
                    stat.data    <= {shreg, ev.sda};
                    stat.is_addr <= (state == RX_ADDR);
                    if (state == RX_ADDR) begin
                        stat.rw  <= ev.sda;
                        claimed  <= claims(hit, mon_en, match_all);
                        ack_want <= hit && !mon_en;
                        state    <= RX_DATA;
                        if (claims(hit, mon_en, match_all)) irq <= 1'b1;
                    end else begin
                        ack_want <= claimed && !stat.rw && !mon_en;
                        if (claimed) irq <= 1'b1;
                    end
                end
                if (ev.fall) begin
                    ack_drv <= (bitcnt == CNT_W'(BYTE_W)) && ack_want;
                    if (post_ack) begin
                        post_ack <= 1'b0;
                        if (irq && !irq_clr && hold_ok) stretch <= 1'b1;
                    end
                end
            end
            if (!hold_ok) stretch <= 1'b0;
            sda_o <= !(ack_drv && !mon_en);
            scl_o <= !(stretch && hold_ok);
        end
    end

    // Rising edges since the last load of the holding register
    logic [3:0] rise_cnt;
    logic       seen_load;

    always_ff @(posedge clk) begin
        if (rst || ev.start || ev.stop) begin
            rise_cnt  <= '0;
            seen_load <= 1'b0;
        end else if (byte_done) begin
            rise_cnt  <= '0;
            seen_load <= 1'b1;
        end else if (ev.rise && rise_cnt != 4'hF) begin
            rise_cnt <= rise_cnt + 1'b1;
        end
    end

    // R2
    sda_released_mon_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mon_en) |-> sda_o);

    // R3
    scl_released_mon_chk: assert property (@(posedge clk) disable iff (rst)
        $past(mon_en && !scl_en) |-> scl_o);

    // R4
    hold_needs_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !scl_o |-> $past(irq));

    // R7
    buffer_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && seen_load) |-> (rise_cnt >= 4'(FRAME_BITS - 1)));

    // R11
    stop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !stop_evt);

endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
    import i2cmon_pkg::*;
#(
    parameter int NUM_ADDR    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       scl_o,
    output logic                       sda_o,
    input  logic                       mon_en,
    input  logic                       scl_en,
    input  logic                       match_all,
    input  logic [NUM_ADDR*ADDR_W-1:0] own_addr,
    input  logic [NUM_ADDR-1:0]        addr_en,
    input  logic                       irq_clr,
    output logic                       irq,
    output logic [BYTE_W-1:0]          rx_data,
    output logic                       rx_is_addr,
    output logic                       rx_rw,
    output logic                       rx_ack,
    output logic                       stop_evt
);

    line_ev_t          ev;
    logic [ADDR_W-1:0] cand;
    logic              hit;
    rx_stat_t          stat;

    i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cmon_match #(.NUM_ADDR(NUM_ADDR)) u_match (
        .own_addr (own_addr),
        .addr_en  (addr_en),
        .cand     (cand),
        .hit      (hit)
    );

    i2cmon_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .mon_en    (mon_en),
        .scl_en    (scl_en),
        .match_all (match_all),
        .hit       (hit),
        .irq_clr   (irq_clr),
        .cand      (cand),
        .stat      (stat),
        .irq       (irq),
        .stop_evt  (stop_evt),
        .sda_o     (sda_o),
        .scl_o     (scl_o)
    );

    assign rx_data    = stat.data;
    assign rx_is_addr = stat.is_addr;
    assign rx_rw      = stat.rw;
    assign rx_ack     = stat.ack;

endmodule

// File: tb/tb_i2cmon_top.sv
`timescale 1ns/1ps
module tb_i2cmon_top;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        scl_m, sda_m;
    logic        scl_o, sda_o;
    logic        mon_en, scl_en, match_all;
    logic [27:0] own_addr;
    logic [3:0]  addr_en;
    logic        irq_clr;
    logic        irq;
    logic [7:0]  rx_data;
    logic        rx_is_addr, rx_rw, rx_ack, stop_evt;
    wire         scl_line = scl_m & scl_o;
    wire         sda_line = sda_m & sda_o;

    int checks = 0;
    int failures = 0;
    int irq_n = 0;
    int stop_n = 0;
    logic stretch_seen = 1'b0;
    logic sda_viol = 1'b0;
    logic [7:0] log_data [4];
    logic       log_isaddr [4];

    always #5 clk = ~clk;

    i2cmon_top dut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_o(scl_o), .sda_o(sda_o), .mon_en(mon_en), .scl_en(scl_en),
        .match_all(match_all), .own_addr(own_addr), .addr_en(addr_en),
        .irq_clr(irq_clr), .irq(irq), .rx_data(rx_data), .rx_is_addr(rx_is_addr),
        .rx_rw(rx_rw), .rx_ack(rx_ack), .stop_evt(stop_evt)
    );

    // {address byte, data byte, mon_en, scl_en, match_all}
    localparam logic [18:0] VEC [9] = '{
        {8'hA0, 8'h3C, 3'b000},
        {8'h46, 8'h81, 3'b000},
        {8'h22, 8'h5A, 3'b000},
        {8'h30, 8'hC3, 3'b001},
        {8'hFE, 8'h77, 3'b110},
        {8'h30, 8'h0F, 3'b101},
        {8'hA1, 8'hE4, 3'b000},
        {8'h46, 8'h99, 3'b100},
        {8'h55, 8'h12, 3'b111}
    };

    function automatic logic own_hit(input logic [6:0] a);
        return (a == 7'h50) || (a == 7'h23) || (a == 7'h7F);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        int n = 0;
        while (!scl_line && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk("R4 clock released", 0, 1);
    endtask

    task automatic send_bit(input logic b, output logic seen);
        sda_m = b;
        wait_cyc(H);
        scl_m = 1'b1;
        wait_high();
        seen = sda_line;
        wait_cyc(H);
        scl_m = 1'b0;
        wait_cyc(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, ack);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        scl_m = 1'b1;
        wait_high();
        wait_cyc(H);
        sda_m = 1'b0;
        wait_cyc(H);
        scl_m = 1'b0;
        wait_cyc(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wait_cyc(H);
        scl_m = 1'b1;
        wait_high();
        wait_cyc(H);
        sda_m = 1'b1;
        wait_cyc(H);
    endtask

    // Interrupt service: log the holding register, clear after a delay
    initial begin
        irq_clr = 1'b0;
        forever begin
            @(negedge clk);
            if (irq) begin
                if (irq_n < 4) begin
                    log_data[irq_n]   = rx_data;
                    log_isaddr[irq_n] = rx_is_addr;
                end
                irq_n++;
                wait_cyc(60);
                irq_clr = 1'b1;
                @(negedge clk);
                irq_clr = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!scl_o) stretch_seen = 1'b1;
            if (mon_en && !sda_o) sda_viol = 1'b1;
            if (stop_evt) stop_n++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: all requirements");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] a, d;
        logic m, se, al, hit, claim, aack, dack, s;
        int stops0, irq0;
        rst = 1'b1;
        scl_m = 1'b1;
        sda_m = 1'b1;
        mon_en = 1'b0;
        scl_en = 1'b0;
        match_all = 1'b0;
        own_addr = {7'h11, 7'h7F, 7'h23, 7'h50};
        addr_en = 4'b0111;
        wait_cyc(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl_o", scl_o, 1);
        chk("R1 sda_o", sda_o, 1);
        chk("R1 irq", irq, 0);
        chk("R1 stop_evt", stop_evt, 0);
        chk("R1 rx_data", rx_data, 8'h00);

        for (int i = 0; i < 9; i++) begin
            a = VEC[i][18:11];
            d = VEC[i][10:3];
            m = VEC[i][2];
            se = VEC[i][1];
            al = VEC[i][0];
            mon_en = m;
            scl_en = se;
            match_all = al;
            wait_cyc(4);
            irq_n = 0;
            stretch_seen = 1'b0;
            sda_viol = 1'b0;
            stops0 = stop_n;
            hit = own_hit(a[7:1]);
            claim = hit || (m && al);
            bus_start();
            send_byte(a, aack);
            send_byte(d, dack);
            bus_stop();
            wait_cyc(120);
            chk($sformatf("R5 R6 irq count vec%0d", i), irq_n, claim ? 2 : 0);
            chk($sformatf("R4 R3 stretch vec%0d", i), stretch_seen, claim && (!m || se));
            chk($sformatf("R9 addr ack vec%0d", i), aack, !(!m && hit));
            chk($sformatf("R9 data ack vec%0d", i), dack, !(!m && hit && !a[0]));
            chk($sformatf("R8 rx_ack vec%0d", i), rx_ack, !(!m && hit && !a[0]));
            chk($sformatf("R7 rx_data vec%0d", i), rx_data, d);
            chk($sformatf("R12 is_addr/rw vec%0d", i), {rx_is_addr, rx_rw}, {1'b0, a[0]});
            chk($sformatf("R11 stop_evt vec%0d", i), stop_n - stops0, 1);
            if (m) chk($sformatf("R2 sda released vec%0d", i), sda_viol, 0);
            if (claim) begin
                chk($sformatf("R7 logged addr vec%0d", i), {log_isaddr[0], log_data[0]}, {1'b1, a});
                chk($sformatf("R7 logged data vec%0d", i), {log_isaddr[1], log_data[1]}, {1'b0, d});
            end
        end

        // R7: holding register unchanged halfway through the next byte
        mon_en = 1'b1; scl_en = 1'b0; match_all = 1'b1;
        wait_cyc(4);
        irq_n = 0;
        bus_start();
        send_byte(8'h9A, aack);
        for (int k = 0; k < 4; k++) send_bit(1'b0, s);
        chk("R7 buffer held mid-frame", rx_data, 8'h9A);
        chk("R12 is_addr mid-frame", rx_is_addr, 1);
        for (int k = 0; k < 4; k++) send_bit(1'b1, s);
        send_bit(1'b1, dack);
        chk("R7 buffer next byte", rx_data, 8'h0F);
        bus_stop();
        wait_cyc(120);

        // R10: repeated START in mid-byte
        mon_en = 1'b1; scl_en = 1'b0; match_all = 1'b0;
        wait_cyc(4);
        irq_n = 0;
        bus_start();
        for (int k = 0; k < 3; k++) send_bit(1'b1, s);
        chk("R10 partial byte not loaded", rx_data, 8'h0F);
        bus_start();
        send_byte(8'h46, aack);
        chk("R10 address after restart", {rx_is_addr, rx_rw, rx_data}, {1'b1, 1'b0, 8'h46});
        chk("R2 no ack in monitor", aack, 1);
        bus_stop();
        wait_cyc(120);
        chk("R10 single irq", irq_n, 1);
        chk("R10 logged address", log_data[0], 8'h46);

        // R4 and R11: hold until cleared, then STOP returns to idle
        mon_en = 1'b0; scl_en = 1'b0; match_all = 1'b0;
        wait_cyc(4);
        irq_n = 0;
        stops0 = stop_n;
        bus_start();
        send_byte(8'hA0, aack);
        wait_cyc(4);
        chk("R4 clock held while irq pending", {irq, scl_o}, 2'b10);
        bus_stop();
        wait_cyc(120);
        chk("R4 released after clear", {irq, scl_o}, 2'b01);
        chk("R11 stop counted", stop_n - stops0, 1);
        irq0 = irq_n;
        scl_m = 1'b0;
        wait_cyc(H);
        send_byte(8'h3C, dack);
        sda_m = 1'b1;
        wait_cyc(H);
        scl_m = 1'b1;
        wait_cyc(120);
        chk("R11 no irq in idle", irq_n, irq0);
        chk("R11 rx_data unchanged in idle", rx_data, 8'hA0);
        chk("R11 no ack in idle", dack, 1);
        chk("R11 no extra stop", stop_n - stops0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule